// File: doc/BRIEF.md
# Keyed User Interrupt Mask Filter

This block holds a small interrupt mask level that user-mode software can raise while it services urgent work, and applies that level to a bank of interrupt request lines. Each request line carries a 4-bit priority. A request survives the filter only when its priority is strictly above the programmed mask level. Of the survivors, the one with the highest priority is reported together with its line index. When several survivors share that priority, the lowest line index is reported.

The mask sits in one 32-bit word on a simple register port that has a select, a write enable, a write word and a read word. A stray store cannot change the mask, because a write takes effect only when a fixed key byte, 8'hA5, sits in the top byte of the same write word. Software raises the mask to hold back less urgent interrupts. It clears the mask to 0 before it gives up the task. The filter result is registered, so it follows its inputs by one clock.

Top module: `keyed_irq_mask_filter`

## Requirements
- R1: On synchronous active-low reset the mask level becomes 0 and accept_o, win_idx_o and win_lvl_o become 0.
- R2: A write (reg_sel=1, reg_we=1) whose bits 31:24 equal 8'hA5 loads bits 7:4 of the write word into the mask level at that clock edge.
- R3: A write whose bits 31:24 differ from 8'hA5 leaves the mask level unchanged.
- R4: While reg_sel=1, reg_rdata returns the mask level in bits 7:4 and 0 in every other bit, whatever was written to those bits. A read changes nothing, and reg_rdata is 0 while reg_sel=0.
- R5: A request whose priority is equal to or below the mask level is never accepted. A mask level of 0 blocks no request that has a non-zero priority.
- R6: A request line with priority 0 is never accepted, whatever the mask level.
- R7: Among surviving requests the highest priority wins, and ties go to the lowest line index. win_idx_o gives that line and win_lvl_o gives its priority. Line i takes its priority from irq_prio[4i+3:4i].
- R8: When no request survives, accept_o, win_idx_o and win_lvl_o are all 0.
- R9: The outputs are registered. They reflect the requests, the priorities and the mask level present during the cycle before the edge that updates them. A mask loaded at edge k therefore first affects the outputs updated at edge k+1.
- R10: A keyed write presented with reg_sel=0 does not change the mask level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register port select, already address-decoded |
| reg_we | input | 1 | Write enable, qualified by reg_sel |
| reg_wdata | input | 32 | Write word: key in 31:24, mask level in 7:4 |
| reg_rdata | output | 32 | Read word: mask level in 7:4, all other bits 0 |
| irq_req | input | 8 | Level-sensitive request lines, one per line |
| irq_prio | input | 32 | Packed priorities, line i in bits 4i+3:4i |
| accept_o | output | 1 | A request survived the mask (registered) |
| win_idx_o | output | 3 | Index of the winning line (registered) |
| win_lvl_o | output | 4 | Priority of the winning line (registered) |

## Verification
A keyed mask write and the registered filter decision can land on the same clock edge. The ordering between them decides whether a request near the new level gets through. The bench holds a request of priority 3 under mask 0 and issues a keyed write of level 3 in the same cycle. It expects the edge that loads the mask to still accept the request, judged against the old level, and the following edge to block it. A table of mask, request and priority vectors covers ties, equal-to-mask blocking, priority 0, and masks 0 and 15. Directed steps cover wrong keys, unselected writes, reserved bits and a reset in mid-run.

// File: rtl/irqmask_pkg.sv
// Shared constants for the keyed user interrupt mask filter.
// Assumes: the defaults below match the 32-bit register word and the 8-line bank.
package irqmask_pkg;
    localparam int unsigned REG_W_DEF   = 32;
    localparam int unsigned LVL_W_DEF   = 4;
    localparam int unsigned NUM_IRQ_DEF = 8;
    localparam int unsigned KEY_W_DEF   = 8;
    localparam logic [7:0]  KEY_DEF     = 8'hA5;
    localparam int unsigned FIELD_LSB_DEF = 4;
endpackage

// File: rtl/mask_keyreg.sv
// Holds the user mask level behind a key byte and formats the read word.
// Assumes: sel is already address-decoded and we is only meaningful with sel.
module mask_keyreg #(
    parameter int unsigned REG_W     = irqmask_pkg::REG_W_DEF,
    parameter int unsigned LVL_W     = irqmask_pkg::LVL_W_DEF,
    parameter int unsigned KEY_W     = irqmask_pkg::KEY_W_DEF,
    parameter logic [KEY_W-1:0] KEY  = irqmask_pkg::KEY_DEF,
    parameter int unsigned FIELD_LSB = irqmask_pkg::FIELD_LSB_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [LVL_W-1:0] mask,
    output logic [REG_W-1:0] rdata
);
    localparam int unsigned KEY_MSB = REG_W - 1;

    logic key_ok;
    logic load;
    logic unused_wbits;

    assign key_ok       = (wdata[KEY_MSB -: KEY_W] == KEY);
    assign load         = sel && we && key_ok;
    assign unused_wbits = ^wdata;

    // Mask level register: loads only on a selected, keyed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (load) begin
            mask <= wdata[FIELD_LSB +: LVL_W];
        end
    end

    // Read word: mask level in its field, every other bit zero.
    always_comb begin
        rdata = '0;
        if (sel) begin
            rdata[FIELD_LSB +: LVL_W] = mask;
        end
    end

    // R2: a keyed write lands in the mask on the next cycle
    assert_keyed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && (wdata[KEY_MSB -: KEY_W] == KEY))
        |=> (mask == $past(wdata[FIELD_LSB +: LVL_W])));

    // R3: a write with the wrong key leaves the mask alone
    assert_bad_key_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && (wdata[KEY_MSB -: KEY_W] != KEY)) |=> $stable(mask));

    // R10: an unselected cycle leaves the mask alone
    assert_unselected_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel) |=> $stable(mask));
endmodule

// File: rtl/irq_prio_select.sv
// Combinational filter and picker: drops requests at or below the mask
// and picks the highest surviving priority, with ties to the lowest index.
// Assumes: priorities are packed line-major, LVL_W bits per line.
module irq_prio_select #(
    parameter int unsigned NUM_IRQ = irqmask_pkg::NUM_IRQ_DEF,
    parameter int unsigned LVL_W   = irqmask_pkg::LVL_W_DEF,
    parameter int unsigned IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_IRQ-1:0]       req,
    input  logic [NUM_IRQ*LVL_W-1:0] prio,
    input  logic [LVL_W-1:0]         mask,
    output logic                     found,
    output logic [IDX_W-1:0]         idx,
    output logic [LVL_W-1:0]         lvl
);
    logic [NUM_IRQ-1:0] survive;

    // Per-line survival: the request must be strictly above the mask level.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        assign survive[g] = req[g] && (prio[g*LVL_W +: LVL_W] > mask);
    end

    // Priority scan: a strict compare keeps the lowest index on a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        lvl   = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (survive[i] && (prio[i*LVL_W +: LVL_W] > lvl)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                lvl   = prio[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/irq_out_reg.sv
// Output stage: registers the filter decision, clearing it on reset.
// Assumes: idx and lvl are already 0 when found is low.
module irq_out_reg #(
    parameter int unsigned LVL_W = irqmask_pkg::LVL_W_DEF,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             found,
    input  logic [IDX_W-1:0] idx,
    input  logic [LVL_W-1:0] lvl,
    output logic             accept_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [LVL_W-1:0] lvl_q
);
    // Decision register: one clock of latency from filter to outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            idx_q    <= '0;
            lvl_q    <= '0;
        end else begin
            accept_q <= found;
            idx_q    <= idx;
            lvl_q    <= lvl;
        end
    end
endmodule

// File: rtl/keyed_irq_mask_filter.sv
// Top: keyed user mask register feeding a registered priority filter.
// Assumes: request lines are synchronous to clk and level-sensitive.
module keyed_irq_mask_filter #(
    parameter int unsigned REG_W     = irqmask_pkg::REG_W_DEF,
    parameter int unsigned LVL_W     = irqmask_pkg::LVL_W_DEF,
    parameter int unsigned NUM_IRQ   = irqmask_pkg::NUM_IRQ_DEF,
    parameter int unsigned KEY_W     = irqmask_pkg::KEY_W_DEF,
    parameter logic [KEY_W-1:0] KEY  = irqmask_pkg::KEY_DEF,
    parameter int unsigned FIELD_LSB = irqmask_pkg::FIELD_LSB_DEF,
    localparam int unsigned IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_sel,
    input  logic                     reg_we,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic [NUM_IRQ-1:0]       irq_req,
    input  logic [NUM_IRQ*LVL_W-1:0] irq_prio,
    output logic                     accept_o,
    output logic [IDX_W-1:0]         win_idx_o,
    output logic [LVL_W-1:0]         win_lvl_o
);
    logic [LVL_W-1:0] mask_lvl;
    logic             sel_found;
    logic [IDX_W-1:0] sel_idx;
    logic [LVL_W-1:0] sel_lvl;

    mask_keyreg #(
        .REG_W(REG_W), .LVL_W(LVL_W), .KEY_W(KEY_W), .KEY(KEY), .FIELD_LSB(FIELD_LSB)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we),
        .wdata(reg_wdata), .mask(mask_lvl), .rdata(reg_rdata)
    );

    irq_prio_select #(
        .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .IDX_W(IDX_W)
    ) u_select (
        .req(irq_req), .prio(irq_prio), .mask(mask_lvl),
        .found(sel_found), .idx(sel_idx), .lvl(sel_lvl)
    );

    irq_out_reg #(
        .LVL_W(LVL_W), .IDX_W(IDX_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .found(sel_found), .idx(sel_idx), .lvl(sel_lvl),
        .accept_q(accept_o), .idx_q(win_idx_o), .lvl_q(win_lvl_o)
    );

    // R5: an accepted level is strictly above the mask of the previous cycle
    assert_above_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (win_lvl_o > $past(mask_lvl)));

    // R6: an accepted winner never carries priority 0
    assert_no_zero_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> (win_lvl_o != '0));

    // R7: the winner was requesting with the reported priority last cycle
    assert_winner_real_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> ((($past(irq_req) >> win_idx_o) & NUM_IRQ'(1)) != '0) &&
                     (LVL_W'($past(irq_prio) >> (win_idx_o * LVL_W)) == win_lvl_o));

    // R8: an idle result carries zero index and level
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept_o) |-> ((win_idx_o == '0) && (win_lvl_o == '0)));
endmodule

// File: tb/tb_keyed_irq_mask_filter.sv
module tb_keyed_irq_mask_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_req = '0;
    logic [31:0] irq_prio = '0;
    logic        accept_o;
    logic [2:0]  win_idx_o;
    logic [3:0]  win_lvl_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    keyed_irq_mask_filter dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_prio(irq_prio), .accept_o(accept_o), .win_idx_o(win_idx_o),
        .win_lvl_o(win_lvl_o)
    );

    // Vector: {mask, req, prio, exp_accept, exp_idx, exp_lvl}
    localparam int NV = 11;
    localparam logic [51:0] VECS [NV] = '{
        {4'h0, 8'h00, 32'h0000_0000, 1'b0, 3'd0, 4'h0},
        {4'h0, 8'h01, 32'h0000_0003, 1'b1, 3'd0, 4'h3},
        {4'h0, 8'hFF, 32'h1234_5678, 1'b1, 3'd0, 4'h8},
        {4'h0, 8'h81, 32'h9000_0002, 1'b1, 3'd7, 4'h9},
        {4'h5, 8'hFF, 32'h5555_5555, 1'b0, 3'd0, 4'h0},
        {4'h5, 8'hFF, 32'h1111_6111, 1'b1, 3'd3, 4'h6},
        {4'h0, 8'h0F, 32'h0000_0000, 1'b0, 3'd0, 4'h0},
        {4'h3, 8'h3C, 32'h00A0_A0A0, 1'b1, 3'd3, 4'hA},
        {4'hF, 8'hFF, 32'hFFFF_FFFF, 1'b0, 3'd0, 4'h0},
        {4'hE, 8'h40, 32'h0F00_0000, 1'b1, 3'd6, 4'hF},
        {4'h0, 8'h80, 32'h1000_0000, 1'b1, 3'd7, 4'h1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic a, input logic [2:0] i,
                           input logic [3:0] l);
        chk({accept_o, win_idx_o, win_lvl_o} == {a, i, l}, req,
            {24'd0, accept_o, win_idx_o, win_lvl_o}, {24'd0, a, i, l});
    endtask

    task automatic keyed_write(input logic [31:0] d, input logic s);
        @(negedge clk);
        reg_sel = s; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_read(output logic [31:0] v);
        reg_sel = 1'b1; reg_we = 1'b0;
        #1 v = reg_rdata;
        reg_sel = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 reset outputs", 1'b0, 3'd0, 4'h0);
        do_read(rv);
        chk(rv == 32'h0, "R1 reset mask", rv, 32'h0);
        reg_sel = 1'b0; #1;
        chk(reg_rdata == 32'h0, "R4 unselected read zero", reg_rdata, 32'h0);

        // Table walk: R5 R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            keyed_write({8'hA5, 16'h0, VECS[v][51:48], 4'h0}, 1'b1);
            irq_req  = VECS[v][47:40];
            irq_prio = VECS[v][39:8];
            @(negedge clk);
            chk_out($sformatf("R7 R5 R6 R8 vector %0d", v),
                    VECS[v][7], VECS[v][6:4], VECS[v][3:0]);
        end
        irq_req = '0;

        // R2 R4: keyed write with junk in reserved bits reads back clean
        keyed_write(32'hA5FF_FF5F, 1'b1);
        do_read(rv);
        chk(rv == 32'h0000_0050, "R2 R4 keyed write readback", rv, 32'h50);
        do_read(rv);
        chk(rv == 32'h0000_0050, "R4 read has no side effect", rv, 32'h50);

        // R3: wrong key
        keyed_write(32'h5AFF_FF9F, 1'b1);
        do_read(rv);
        chk(rv == 32'h0000_0050, "R3 wrong key ignored", rv, 32'h50);
        keyed_write(32'hA4FF_FF9F, 1'b1);
        do_read(rv);
        chk(rv == 32'h0000_0050, "R3 near key ignored", rv, 32'h50);

        // R10: keyed write with select low
        keyed_write(32'hA500_0090, 1'b0);
        do_read(rv);
        chk(rv == 32'h0000_0050, "R10 unselected write ignored", rv, 32'h50);

        // R9 same-cycle: mask 0 with line1 at priority 3, then write level 3
        keyed_write(32'hA500_0000, 1'b1);
        irq_req = 8'h02; irq_prio = 32'h0000_0030;
        @(negedge clk);
        reg_sel = 1'b1; reg_we = 1'b1; reg_wdata = 32'hA500_0030;
        @(negedge clk);
        reg_sel = 1'b0; reg_we = 1'b0; reg_wdata = '0;
        chk_out("R9 old mask on load edge", 1'b1, 3'd1, 4'h3);
        @(negedge clk);
        chk_out("R9 R5 new mask blocks equal level", 1'b0, 3'd0, 4'h0);

        // R1: reset mid-run clears mask and outputs
        keyed_write(32'hA500_0000, 1'b1);
        @(negedge clk);
        chk_out("R5 mask 0 passes level 3", 1'b1, 3'd1, 4'h3);
        keyed_write(32'hA500_0070, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_out("R1 mid-run reset outputs", 1'b0, 3'd0, 4'h0);
        do_read(rv);
        chk(rv == 32'h0, "R1 mid-run reset mask", rv, 32'h0);
        @(negedge clk);
        chk_out("R1 request passes after reset", 1'b1, 3'd1, 4'h3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule